// File: doc/BRIEF.md
# Output Compare Channel with Double-Buffered Compare Value

This block is one compare channel of a 16-bit capture/compare timer. It watches the running timer count and compares it against an active compare value. On a match it raises a sticky interrupt flag and applies a selectable action to an output latch that can drive a pin. Software can also force that action at any time. A forced action leaves the flag untouched.

Software reaches the channel through a small byte-wide write port. Two byte writes fill a high and a low shadow register. The active compare value changes only when a separate update strobe arrives, so a new value never takes effect half-written. A control register holds the action mode, the force bit and the pin connection. The interrupt request is the flag gated by three enable inputs.

A match event is taken on the first cycle of equality. A count that stays equal for several cycles acts only once.

Top module: `ocmp_channel`

## Requirements
- R1: While `rst` is high at a clock edge, the following are cleared after that edge: `cmp_out`, `cmp_flag`, `cmp_active`, `upd_busy` and the control register. The mode field then reads 00 and `cmp_oe` is 0.
- R2: When `timer_cnt` equals `cmp_active` at clock edge k, `cmp_flag` stays unchanged after edge k and is set after edge k+1.
- R3: `cmp_flag` clears only when software writes address 3 with data bit 0 equal to 0. Writing bit 0 as 1 has no effect. If a clear write and a flag-setting match event fall on the same edge, the flag ends set.
- R4: The control register sits at address 2, with the mode field in bits 1:0. On a match event the latch responds to the mode: 00 leaves it alone, 01 sets it, 10 clears it and 11 toggles it. The action happens at the same edge as the flag, whatever the enable inputs are.
- R5: `cmp_out` keeps its value in every cycle that has no match event and no forced compare.
- R6: Writing address 2 with bit 2 set starts a forced compare. The mode written in that same write is applied to the latch one edge later, and `cmp_flag` is not set.
- R7: Bit 2 of `rd_ctrl` always reads 0. Bits 1:0 return the mode, bit 3 returns the output enable (`cmp_oe`), and the remaining bits read 0.
- R8: Writes to address 0 (low byte) and address 1 (high byte) go only to the shadow registers. `cmp_active` does not change until an update.
- R9: An `upd_strobe` pulse accepted at edge k raises `upd_busy` after edge k. `cmp_active` takes the shadow contents at edge k+1, and `upd_busy` falls after edge k+2. Strobes that arrive while `upd_busy` is high are ignored.
- R10: `irq` equals `cmp_flag` AND `gbl_ie` AND `chn_ie` AND `unit_ie`.
- R11: If the timer stays equal to the compare value for several cycles, only one match event results, so a toggle mode toggles once.
- R12: If a forced compare and a match event act at the same edge, the mode action is applied once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_cnt | input | 16 | Running timer count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 low shadow, 1 high shadow, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| upd_strobe | input | 1 | Request to move the shadow registers into the active compare value |
| gbl_ie | input | 1 | Global interrupt enable |
| chn_ie | input | 1 | Channel interrupt enable |
| unit_ie | input | 1 | Timer unit interrupt enable |
| cmp_out | output | 1 | Compare output latch |
| cmp_oe | output | 1 | Connects the latch to the pin |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Gated interrupt request |
| cmp_active | output | 16 | Active compare value |
| upd_busy | output | 1 | Update in progress |
| rd_ctrl | output | 8 | Control register readback |

## Verification
Two coincidences are provoked on purpose. In the first, the timer equals the compare value at the same edge as a force write, with the mode set to toggle. A single inversion of `cmp_out` is the pass result; a double inversion or none is a failure. In the second, a status clear write is placed on the edge where the flag would be set, and the flag must end high. Random traffic also lets these cases collide by chance, and a cycle-accurate model built from the requirements judges every cycle.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [1:0] {
    OM_NONE = 2'b00,
    OM_SET  = 2'b01,
    OM_CLR  = 2'b10,
    OM_TGL  = 2'b11
  } om_e;

  typedef enum logic [1:0] {
    UP_IDLE = 2'b00,
    UP_LOAD = 2'b01,
    UP_DONE = 2'b10
  } up_e;

  localparam logic [1:0] RA_SHL = 2'd0;
  localparam logic [1:0] RA_SHH = 2'd1;
  localparam logic [1:0] RA_CTL = 2'd2;
  localparam logic [1:0] RA_STS = 2'd3;

  localparam int CB_FRC = 2;
  localparam int CB_OE  = 3;

  function automatic logic om_apply(input om_e m, input logic cur);
    case (m)
      OM_SET:  return 1'b1;
      OM_CLR:  return 1'b0;
      OM_TGL:  return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/ocmp_shadow.sv
module ocmp_shadow #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [CW/2-1:0] wr_byte,
  input  logic            upd_req,
  output logic [CW-1:0]   act_cmp,
  output logic            busy
);
  import ocmp_pkg::*;

  localparam int HW = CW / 2;

  logic [HW-1:0] sh_lo, sh_hi;
  up_e           st;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_lo <= '0;
      sh_hi <= '0;
    end else begin
      if (wr_lo) sh_lo <= wr_byte;
      if (wr_hi) sh_hi <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= UP_IDLE;
      act_cmp <= '0;
    end else begin
      case (st)
        UP_IDLE: if (upd_req) st <= UP_LOAD;
        UP_LOAD: begin
          act_cmp <= {sh_hi, sh_lo};
          st      <= UP_DONE;
        end
        default: st <= UP_IDLE;
      endcase
    end
  end

  assign busy = (st != UP_IDLE);

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] timer,
  input  logic [CW-1:0] cmp,
  output logic          evt
);
  logic eq_q, eq_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_q <= 1'b0;
      eq_d <= 1'b0;
    end else begin
      eq_q <= (timer == cmp);
      eq_d <= eq_q;
    end
  end

  assign evt = eq_q & ~eq_d;

endmodule

// File: rtl/ocmp_action.sv
module ocmp_action (
  input  logic           clk,
  input  logic           rst,
  input  logic           evt,
  input  logic           frc,
  input  ocmp_pkg::om_e  mode,
  input  logic           clr,
  output logic           latch,
  output logic           flag
);
  import ocmp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (evt || frc) latch <= om_apply(mode, latch);
      if (evt)        flag  <= 1'b1;
      else if (clr)   flag  <= 1'b0;
    end
  end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int CW = 16,
  parameter int DW = CW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] timer_cnt,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          upd_strobe,
  input  logic          gbl_ie,
  input  logic          chn_ie,
  input  logic          unit_ie,
  output logic          cmp_out,
  output logic          cmp_oe,
  output logic          cmp_flag,
  output logic          irq,
  output logic [CW-1:0] cmp_active,
  output logic          upd_busy,
  output logic [DW-1:0] rd_ctrl
);
  import ocmp_pkg::*;

  om_e  mode_q;
  logic oe_q, frc_q, evt;

  wire wr_ctl = wr_en && (wr_addr == RA_CTL);
  wire wr_clr = wr_en && (wr_addr == RA_STS) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= OM_NONE;
      oe_q   <= 1'b0;
      frc_q  <= 1'b0;
    end else begin
      frc_q <= wr_ctl && wr_data[CB_FRC];
      if (wr_ctl) begin
        mode_q <= om_e'(wr_data[1:0]);
        oe_q   <= wr_data[CB_OE];
      end
    end
  end

  ocmp_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && (wr_addr == RA_SHL)),
    .wr_hi(wr_en && (wr_addr == RA_SHH)),
    .wr_byte(wr_data),
    .upd_req(upd_strobe),
    .act_cmp(cmp_active),
    .busy(upd_busy)
  );

  ocmp_match #(.CW(CW)) u_match (
    .clk(clk), .rst(rst),
    .timer(timer_cnt), .cmp(cmp_active),
    .evt(evt)
  );

  ocmp_action u_action (
    .clk(clk), .rst(rst),
    .evt(evt), .frc(frc_q), .mode(mode_q), .clr(wr_clr),
    .latch(cmp_out), .flag(cmp_flag)
  );

  assign cmp_oe  = oe_q;
  assign irq     = cmp_flag & gbl_ie & chn_ie & unit_ie;
  assign rd_ctrl = DW'({oe_q, 1'b0, mode_q});

endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
  parameter int CW = 16,
  parameter int DW = CW / 2
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] timer_cnt,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cmp_out,
  input logic          cmp_flag,
  input logic [CW-1:0] cmp_active,
  input logic          upd_busy,
  input logic [DW-1:0] rd_ctrl
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!cmp_out && !cmp_flag && !upd_busy && cmp_active == '0));

  a_r2_flag_after_match: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> $past(timer_cnt == cmp_active, 2));

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !(wr_en && wr_addr == 2'd3 && !wr_data[0])) |=> cmp_flag);

  a_r7_force_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_ctrl[2]);

  a_r8_active_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_busy |=> $stable(cmp_active));

  a_r9_busy_two_cycles: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_busy) |=> upd_busy);

  a_r9_busy_falls: assert property (@(posedge clk) disable iff (rst)
    (upd_busy && $past(upd_busy)) |=> !upd_busy);

endmodule

bind ocmp_channel ocmp_channel_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .timer_cnt(timer_cnt), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .cmp_out(cmp_out),
  .cmp_flag(cmp_flag), .cmp_active(cmp_active), .upd_busy(upd_busy),
  .rd_ctrl(rd_ctrl)
);

// File: tb/test_ocmp_channel.sv
module test_ocmp_channel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] timer_cnt = 16'hFFFF;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        upd_strobe = 1'b0;
  logic        gbl_ie = 1'b0, chn_ie = 1'b0, unit_ie = 1'b0;
  logic        cmp_out, cmp_oe, cmp_flag, irq, upd_busy;
  logic [15:0] cmp_active;
  logic [7:0]  rd_ctrl;

  int n_run = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  ocmp_channel i_ocmp_channel (
    .clk(clk), .rst(rst), .timer_cnt(timer_cnt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .upd_strobe(upd_strobe),
    .gbl_ie(gbl_ie), .chn_ie(chn_ie), .unit_ie(unit_ie),
    .cmp_out(cmp_out), .cmp_oe(cmp_oe), .cmp_flag(cmp_flag), .irq(irq),
    .cmp_active(cmp_active), .upd_busy(upd_busy), .rd_ctrl(rd_ctrl)
  );

  // Reference model built from the requirements
  logic [15:0] m_act;
  logic [7:0]  m_shl, m_shh;
  logic [1:0]  m_mode, m_st;
  logic        m_oe, m_frc, m_eq, m_eqd, m_out, m_flag;

  function automatic logic f_apply(input logic [1:0] m, input logic cur);
    case (m)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act <= '0; m_shl <= '0; m_shh <= '0; m_mode <= '0; m_st <= '0;
      m_oe <= 0; m_frc <= 0; m_eq <= 0; m_eqd <= 0; m_out <= 0; m_flag <= 0;
    end else begin
      m_eq  <= (timer_cnt == m_act);
      m_eqd <= m_eq;
      m_frc <= wr_en && wr_addr == 2'd2 && wr_data[2];
      if (wr_en && wr_addr == 2'd2) begin m_mode <= wr_data[1:0]; m_oe <= wr_data[3]; end
      if (wr_en && wr_addr == 2'd0) m_shl <= wr_data;
      if (wr_en && wr_addr == 2'd1) m_shh <= wr_data;
      case (m_st)
        2'd0: if (upd_strobe) m_st <= 2'd1;
        2'd1: begin m_act <= {m_shh, m_shl}; m_st <= 2'd2; end
        default: m_st <= 2'd0;
      endcase
      if ((m_eq && !m_eqd) || m_frc) m_out <= f_apply(m_mode, m_out);
      if (m_eq && !m_eqd) m_flag <= 1'b1;
      else if (wr_en && wr_addr == 2'd3 && !wr_data[0]) m_flag <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk("R4 cmp_out", {15'd0, cmp_out}, {15'd0, m_out});
      chk("R3 cmp_flag", {15'd0, cmp_flag}, {15'd0, m_flag});
      chk("R8 cmp_active", cmp_active, m_act);
      chk("R9 upd_busy", {15'd0, upd_busy}, {15'd0, m_st != 2'd0});
      chk("R10 irq", {15'd0, irq}, {15'd0, m_flag & gbl_ie & chn_ie & unit_ie});
      chk("R7 rd_ctrl", {8'd0, rd_ctrl}, {12'd0, m_oe, 1'b0, m_mode});
    end
  end

  task automatic tick(); @(negedge clk); #0.5; endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic load_cmp(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
    upd_strobe = 1'b1; tick(); upd_strobe = 1'b0;
    tick(); tick();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic o;
    void'($urandom(32'h0C0FFEE));
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    chk("R1 out", {15'd0, cmp_out}, 16'd0);
    chk("R1 flag", {15'd0, cmp_flag}, 16'd0);
    chk("R1 active", cmp_active, 16'd0);
    chk("R1 rd_ctrl", {8'd0, rd_ctrl}, 16'd0);
    chk("R1 oe", {15'd0, cmp_oe}, 16'd0);
    mon_on = 1'b1;

    // R8: shadow writes leave the active value alone
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    tick();
    chk("R8 no early load", cmp_active, 16'h0000);
    // R9: update timing
    upd_strobe = 1'b1; tick(); upd_strobe = 1'b0;
    chk("R9 busy raised", {15'd0, upd_busy}, 16'd1);
    chk("R9 not yet loaded", cmp_active, 16'h0000);
    upd_strobe = 1'b1; tick(); upd_strobe = 1'b0;
    chk("R9 loaded", cmp_active, 16'h1234);
    tick();
    chk("R9 busy fell", {15'd0, upd_busy}, 16'd0);

    // R2: flag one edge after the compare; R4 set mode with enables off
    wr(2'd2, 8'h09);
    chk("R7 oe readback", {15'd0, cmp_oe}, 16'd1);
    timer_cnt = 16'h1234; tick(); timer_cnt = 16'h0001;
    chk("R2 not same cycle", {15'd0, cmp_flag}, 16'd0);
    tick();
    chk("R2 flag set", {15'd0, cmp_flag}, 16'd1);
    chk("R4 set action", {15'd0, cmp_out}, 16'd1);
    // R3: writing 1 does nothing, writing 0 clears
    wr(2'd3, 8'h01);
    chk("R3 write one ignored", {15'd0, cmp_flag}, 16'd1);
    wr(2'd3, 8'h00);
    chk("R3 cleared", {15'd0, cmp_flag}, 16'd0);

    // R6: forced toggle, no flag; R7 force bit reads 0
    wr(2'd2, 8'h07);
    chk("R7 force reads 0", {8'd0, rd_ctrl}, 16'h0003);
    tick();
    chk("R6 forced toggle", {15'd0, cmp_out}, 16'd0);
    chk("R6 no flag", {15'd0, cmp_flag}, 16'd0);
    // R5: mode none holds through a match
    wr(2'd2, 8'h00);
    timer_cnt = 16'h1234; tick(); timer_cnt = 16'h0002; tick(); tick();
    chk("R5 hold", {15'd0, cmp_out}, 16'd0);
    wr(2'd3, 8'h00);

    // R11: held equality toggles once
    wr(2'd2, 8'h03);
    timer_cnt = 16'h1234; tick(); tick(); tick(); tick();
    timer_cnt = 16'h0003; tick();
    chk("R11 single toggle", {15'd0, cmp_out}, 16'd1);

    // R12: force write and match together act once; R3 set beats clear
    o = cmp_out;
    timer_cnt = 16'h1234;
    wr(2'd2, 8'h07);
    timer_cnt = 16'h0004;
    wr(2'd3, 8'h00);
    chk("R12 one toggle", {15'd0, cmp_out}, {15'd0, ~o});
    chk("R3 set beats clear", {15'd0, cmp_flag}, 16'd1);

    // R10: interrupt gating
    gbl_ie = 1; chn_ie = 1; unit_ie = 0; tick();
    chk("R10 gated off", {15'd0, irq}, 16'd0);
    unit_ie = 1; tick();
    chk("R10 on", {15'd0, irq}, 16'd1);

    // Random phase, judged by the model every cycle
    load_cmp(16'h0040);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 16;
      timer_cnt = (r < 6) ? m_act : 16'($urandom % 80);
      gbl_ie = 1'($urandom); chn_ie = 1'($urandom); unit_ie = 1'($urandom);
      upd_strobe = (($urandom % 24) == 0);
      wr_en = (($urandom % 5) == 0);
      wr_addr = 2'($urandom);
      wr_data = (wr_addr < 2'd2) ? ((wr_addr == 2'd1) ? 8'd0 : 8'($urandom % 80)) : 8'($urandom);
      tick();
    end
    wr_en = 0; upd_strobe = 0;
    tick();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule